// File: doc/BRIEF.md
# Tagged Run-Length Encoder

This block compresses a stream of narrow input values, one per clock, into wider tagged output words. The first sample of every run of equal values goes out as a literal word; the number of extra repeats that follow it goes out as a separate count word once the run ends. The top bit of each output word tells a decoder which of the two kinds it holds, and a strobe marks the cycles in which a word is present.

Internally a datapath keeps the previous sample, a repeat counter and an equality comparator, and a four-state controller decides each cycle whether to clear or advance the counter and whether to emit a literal or a count. Two warm-up states after reset prime the previous-sample register before anything is emitted. A run too long for the counter is split: a full count word is sent and counting restarts, so no count is ever lost to wrap-around.

Top module: `rle_encoder`

## Requirements
- R1: A literal word has bit 7 (the top bit) at 0 and the sample value in bits 6:0; exactly one literal is emitted for the first sample of each run.
- R2: A count word has bit 7 at 1 and, in bits 6:0, the number of further samples equal to the preceding literal (a run of length L yields a count of L-1 when L-1 is below 127).
- R3: Whenever `dout_vld` is low, `dout` is all zeros.
- R4: After synchronous reset is released, `dout_vld` stays low for the first two clock edges; the sample taken at the second edge is the first stream value.
- R5: A literal word becomes visible two clock edges after the edge that sampled that value.
- R6: A count word becomes visible after the edge that samples the first differing value, and the literal for that new value follows on the next cycle; a run of length one produces no count word.
- R7: When the repeat counter holds 127 and another equal sample arrives, a count word of 127 is emitted and counting restarts at 1; a count word never carries 0.
- R8: Two count words are emitted back to back only when the first one carries 127.
- R9: Decoding the output (literal appends its value, count n appends the last literal n more times) reproduces the input stream in order.
- R10: Asserting reset in the middle of a run clears the outputs to zero and the encoder restarts with the two warm-up cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 7 | Input sample, one per clock |
| dout | output | 8 | Tagged output word (bit 7: 0 literal, 1 count) |
| dout_vld | output | 1 | High in cycles where `dout` holds a word |

## Verification
The assertions assume the input is a defined value on every clock after reset, since the literal check relates an emitted word to the sample two edges earlier and the count checks rely on the comparator seeing real values. The stimulus drives `din` on the falling edge from time zero, holds reset for two full cycles, and includes runs of exactly 128 and far beyond 127 samples so the saturation split and back-to-back count words actually occur, as well as single-sample runs where no count word may appear.

// File: rtl/rle_pkg.sv
package rle_pkg;

  // Controller states: two warm-up states, then literal and repeat states.
  typedef enum logic [1:0] {
    ST_WARM_A = 2'd0,
    ST_WARM_B = 2'd1,
    ST_LIT    = 2'd2,
    ST_REP    = 2'd3
  } rle_state_e;

endpackage

// File: rtl/rle_datapath.sv
module rle_datapath #(
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              cnt_clr,
  input  logic              cnt_inc,
  output logic [DATA_W-1:0] prev_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic              eq,
  output logic              sat
);

  localparam logic [DATA_W-1:0] CNT_MAX = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] CNT_ONE = DATA_W'(1);

  // Previous-sample register: follows the input every cycle.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= din;
  end

  // Repeat counter: clear, clear-and-count-one, or advance.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_clr) begin
      cnt_q <= cnt_inc ? CNT_ONE : '0;
    end else if (cnt_inc) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  assign eq  = (din == prev_q);
  assign sat = (cnt_q == CNT_MAX);

endmodule

// File: rtl/rle_ctrl.sv
module rle_ctrl
  import rle_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic eq,
  input  logic sat,
  output logic cnt_clr,
  output logic cnt_inc,
  output logic emit,
  output logic tag_cnt
);

  rle_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_WARM_A;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    emit    = 1'b0;
    tag_cnt = 1'b0;
    unique case (state_q)
      ST_WARM_A: state_d = ST_WARM_B;
      ST_WARM_B: state_d = ST_LIT;
      ST_LIT: begin
        emit    = 1'b1;
        cnt_clr = 1'b1;
        cnt_inc = eq;
        state_d = eq ? ST_REP : ST_LIT;
      end
      ST_REP: begin
        if (!eq) begin
          emit    = 1'b1;
          tag_cnt = 1'b1;
          state_d = ST_LIT;
        end else if (sat) begin
          emit    = 1'b1;
          tag_cnt = 1'b1;
          cnt_clr = 1'b1;
          cnt_inc = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      default: state_d = ST_WARM_A;
    endcase
  end

endmodule

// File: rtl/rle_outreg.sv
module rle_outreg #(
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              emit,
  input  logic              tag_cnt,
  input  logic [DATA_W-1:0] prev_q,
  input  logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W:0]   dout,
  output logic              dout_vld
);

  logic [DATA_W:0] word_d;

  always_comb begin
    if (!emit)        word_d = '0;
    else if (tag_cnt) word_d = {1'b1, cnt_q};
    else              word_d = {1'b0, prev_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout     <= word_d;
      dout_vld <= emit;
    end
  end

endmodule

// File: rtl/rle_encoder.sv
module rle_encoder #(
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W:0]   dout,
  output logic              dout_vld
);

  logic [DATA_W-1:0] prev_q;
  logic [DATA_W-1:0] cnt_q;
  logic              eq, sat;
  logic              cnt_clr, cnt_inc, emit, tag_cnt;

  rle_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .cnt_clr (cnt_clr),
    .cnt_inc (cnt_inc),
    .prev_q  (prev_q),
    .cnt_q   (cnt_q),
    .eq      (eq),
    .sat     (sat)
  );

  rle_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .eq      (eq),
    .sat     (sat),
    .cnt_clr (cnt_clr),
    .cnt_inc (cnt_inc),
    .emit    (emit),
    .tag_cnt (tag_cnt)
  );

  rle_outreg #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .emit     (emit),
    .tag_cnt  (tag_cnt),
    .prev_q   (prev_q),
    .cnt_q    (cnt_q),
    .dout     (dout),
    .dout_vld (dout_vld)
  );

endmodule

// File: rtl/rle_encoder_chk.sv
module rle_encoder_chk #(
  parameter int DATA_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W:0]   dout,
  input logic              dout_vld
);

  localparam logic [DATA_W-1:0] CNT_MAX = {DATA_W{1'b1}};

  logic is_cnt, is_lit;
  assign is_cnt = dout_vld &&  dout[DATA_W];
  assign is_lit = dout_vld && !dout[DATA_W];

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !dout_vld |-> (dout == '0));

  assert_warmup_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) || $past(rst, 2)) |-> !dout_vld);

  assert_literal_latency_R5: assert property (@(posedge clk) disable iff (rst)
    is_lit |-> (dout[DATA_W-1:0] == $past(din, 2)));

  assert_count_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    is_cnt |-> (dout[DATA_W-1:0] != '0));

  assert_count_pair_R8: assert property (@(posedge clk) disable iff (rst)
    (is_cnt && dout[DATA_W-1:0] != CNT_MAX) |=> !is_cnt);

  assert_count_then_literal_R6: assert property (@(posedge clk) disable iff (rst)
    (is_cnt && dout[DATA_W-1:0] != CNT_MAX) |=> is_lit);

endmodule

bind rle_encoder rle_encoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .din      (din),
  .dout     (dout),
  .dout_vld (dout_vld)
);

// File: tb/rle_encoder_test.sv
module rle_encoder_test;

  localparam int  DW = 7;
  localparam int  MAXC = (1 << DW) - 1;
  localparam time CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW:0]   dout;
  logic          dout_vld;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rle_encoder #(.DATA_W(DW)) uut (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .dout     (dout),
    .dout_vld (dout_vld)
  );

  int checks = 0;
  int errors = 0;

  // Behavioural reference state.
  int ph, mprev, mrun;
  bit exp_v;
  int exp_w;
  int sent[$];
  int rebuilt[$];
  int last_lit;
  int last_val;

  task automatic model_step(input int x);
    if (ph < 2) begin
      exp_v = 1'b0; exp_w = 0;
      if (ph == 1) sent.push_back(x);
      ph++;
    end else begin
      sent.push_back(x);
      if (mrun == 0) begin
        exp_v = 1'b1; exp_w = mprev;
        if (x == mprev) mrun = 1;
      end else if (x != mprev) begin
        exp_v = 1'b1; exp_w = 128 + mrun; mrun = 0;
      end else if (mrun == MAXC) begin
        exp_v = 1'b1; exp_w = 128 + MAXC; mrun = 1;
      end else begin
        exp_v = 1'b0; exp_w = 0; mrun++;
      end
    end
    mprev = x;
  endtask

  task automatic observe();
    string req;
    if (!exp_v)               req = "R3";
    else if (exp_w < 128)     req = "R1/R5";
    else if (exp_w == 255)    req = "R7";
    else                      req = "R2/R6";
    // R8 is covered too: the reference only emits back-to-back counts after 127.
    checks++;
    if (dout_vld !== exp_v || int'(dout) != exp_w) begin
      errors++;
      $display("FAIL %s: valid=%0b word=%0h expected valid=%0b word=%0h",
               req, dout_vld, dout, exp_v, exp_w);
    end
    if (dout_vld === 1'b1) begin
      if (!dout[DW]) begin
        last_lit = int'(dout[DW-1:0]);
        rebuilt.push_back(last_lit);
      end else begin
        for (int k = 0; k < int'(dout[DW-1:0]); k++) rebuilt.push_back(last_lit);
      end
    end
  endtask

  task automatic tick(input int x);
    @(negedge clk);
    observe();
    din = x[DW-1:0];
    model_step(x);
    last_val = x;
  endtask

  task automatic send_run(input int v, input int len);
    for (int i = 0; i < len; i++) tick(v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    din = '0;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (dout_vld !== 1'b0 || dout !== '0) begin
      errors++;
      $display("FAIL R4/R10: reset valid=%0b word=%0h expected valid=0 word=0",
               dout_vld, dout);
    end
    rst = 1'b0;
    ph = 0; mprev = 0; mrun = 0; exp_v = 1'b0; exp_w = 0;
    sent.delete(); rebuilt.delete(); last_lit = 0; last_val = -1;
    model_step(0);
  endtask

  task automatic check_decode();
    checks++;
    if (rebuilt.size() == 0 || rebuilt.size() > sent.size()) begin
      errors++;
      $display("FAIL R9: decoded length=%0d expected 1..%0d", rebuilt.size(), sent.size());
    end
    for (int i = 0; i < rebuilt.size() && i < sent.size(); i++) begin
      checks++;
      if (rebuilt[i] != sent[i]) begin
        errors++;
        $display("FAIL R9: decoded[%0d]=%0d expected %0d", i, rebuilt[i], sent[i]);
      end
    end
  endtask

  function automatic int fresh_value();
    int v;
    v = int'($urandom_range(0, MAXC));
    if (v == last_val) v = (v + 1) % (MAXC + 1);
    return v;
  endfunction

  task automatic flush();
    tick(10); tick(11); tick(12);
  endtask

  initial begin
    do_reset();
    // R4: warm-up cycles stay quiet.
    for (int i = 0; i < 10; i++) tick(i);            // single-sample runs, R6
    send_run(20, 2); send_run(21, 3); send_run(20, 2);
    for (int r = 0; r < 60; r++) send_run(fresh_value(), int'($urandom_range(1, 12)));
    send_run(3, 128);                                 // count of exactly 127
    send_run(5, 129);                                 // saturate then count 1, R7
    send_run(6, 300);                                 // several saturations, R8
    send_run(MAXC, 2);                                // largest literal value
    flush();
    check_decode();
    // R10: reset in the middle of a run.
    send_run(40, 7);
    do_reset();
    send_run(41, 4); send_run(42, 1); send_run(41, 3);
    flush();
    check_decode();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule